// File: doc/BRIEF.md
# Wired-OR Bus Frame Master

This block is the only timing source on a shared active-low serial line where every attached device can pull the line down. It sends frames back to back without pause. Each frame begins with a synchronisation header and is followed by `NBITS` data slots. The master alone starts every data slot by pulling the line low. A slot is worth 0 unless a slave asks for a 1 early in that slot. When that happens, the master stretches its own low pulse, so the slot goes out as a 1 within that same slot.

Time is counted in sub-ticks, one for each cycle of the `tick` strobe, and a bit time is `SUBTICKS` sub-ticks long. An external comparator detects that a slave is pulling the line lower than the master does, and reports this on `req_seen`. At the end of each frame the block presents the decoded data bits as a word.

Top module: `oc_frame_master`

## Requirements
- R1: Frames repeat without pause. Each frame is a header of three bit times, during which `in_sync` is 1 and `slot_idx` is 0, followed by `NBITS` data slots, during which `in_sync` is 0 and `slot_idx` counts from 0 up to `NBITS-1`.
- R2: In the header, `bus_pull` is 1 for the first two bit times (40 sub-ticks) and 0 for the third bit time. This gives data slot 0 its own falling edge.
- R3: In a data slot with no accepted request, `bus_pull` is 1 during sub-ticks 0 to 4 and 0 during sub-ticks 5 to 19. The slot's bit is then 0.
- R4: If `req_seen` is 1 in any clock cycle while the slot is at sub-tick 1, 2, 3 or 4, `bus_pull` stays 1 through sub-tick 14 and is 0 during sub-ticks 15 to 19. The slot's bit is then 1.
- R5: `req_seen` has no effect at data sub-tick 0, at data sub-ticks 5 to 19, or anywhere in the header. The line waveform and the slot's bit stay as described in R3.
- R6: The tick that ends the last data slot loads `frame_bits`, with bit i holding the value of data slot i. In that same cycle `frame_done` goes to 1 for exactly one clock.
- R7: `bus_pull`, `in_sync` and `slot_idx` change only in a clock cycle that follows a `tick` strobe.
- R8: While reset is applied, and after it is released, the block is at sub-tick 0 of the header. So `bus_pull`=1, `in_sync`=1, `slot_idx`=0, `frame_bits`=0 and `frame_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sub-tick strobe, one clock wide |
| req_seen | input | 1 | Comparator flag: a slave is pulling the line extra low |
| bus_pull | output | 1 | 1 = drive the line low |
| in_sync | output | 1 | 1 while the header is being sent |
| slot_idx | output | $clog2(NBITS) | Current data slot |
| frame_bits | output | NBITS | Data bits of the last complete frame |
| frame_done | output | 1 | One-clock strobe when `frame_bits` is loaded |

## Verification
Two things can happen on the same edge. The tick that closes the last data slot also loads the frame word and pulses `frame_done`. So the request accepted in that last slot has to reach the word in that same cycle. Separately, a frame in which `req_seen` is held high all the time places a request on every slot boundary, in every header sub-tick and in every window. The bench expects every data bit to be 1, the header waveform to stay unchanged, and no request to carry over into the next slot. Other frames place requests one sub-tick outside the window on each side, at 0 and 5, as well as at each window sub-tick. The bench compares every sub-tick of the line against its own position count.

// File: rtl/oc_frame_master.sv
module oc_frame_master #(
  parameter int NBITS     = 8,
  parameter int SUBTICKS  = 20,
  parameter int WIN_FIRST = 1,
  parameter int WIN_LAST  = 4,
  parameter int SHORT_LEN = 5,
  parameter int LONG_LEN  = 15,
  parameter int SYNC_LOW  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     req_seen,
  output logic                     bus_pull,
  output logic                     in_sync,
  output logic [$clog2(NBITS)-1:0] slot_idx,
  output logic [NBITS-1:0]         frame_bits,
  output logic                     frame_done
);
  localparam int SW  = $clog2(SUBTICKS);
  localparam int SLW = $clog2(NBITS);
  localparam int HDR = SYNC_LOW + 1;
  localparam int HW  = $clog2(HDR + 1);
  localparam logic [SW-1:0]  SUB_LAST  = SW'(SUBTICKS - 1);
  localparam logic [SW-1:0]  W_LO      = SW'(WIN_FIRST);
  localparam logic [SW-1:0]  W_HI      = SW'(WIN_LAST);
  localparam logic [SW-1:0]  SHORT_END = SW'(SHORT_LEN);
  localparam logic [SW-1:0]  LONG_END  = SW'(LONG_LEN);
  localparam logic [HW-1:0]  HDR_LAST  = HW'(HDR - 1);
  localparam logic [HW-1:0]  SYNC_N    = HW'(SYNC_LOW);
  localparam logic [SLW-1:0] SLOT_LAST = SLW'(NBITS - 1);

  logic [SW-1:0]    sub;
  logic [HW-1:0]    hdr_cnt;
  logic             hdr;
  logic [SLW-1:0]   slot;
  logic             stretch;
  logic [NBITS-1:0] cap, cap_next;

  wire slot_end = tick && (sub == SUB_LAST);
  wire in_win   = !hdr && (sub >= W_LO) && (sub <= W_HI);

  always_comb begin
    cap_next       = cap;
    cap_next[slot] = stretch;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub        <= '0;
      hdr_cnt    <= '0;
      hdr        <= 1'b1;
      slot       <= '0;
      stretch    <= 1'b0;
      cap        <= '0;
      frame_bits <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (in_win && req_seen) stretch <= 1'b1;
      if (tick) sub <= slot_end ? '0 : sub + 1'b1;
      if (slot_end) begin
        stretch <= 1'b0;
        if (hdr) begin
          if (hdr_cnt == HDR_LAST) begin
            hdr     <= 1'b0;
            hdr_cnt <= '0;
            slot    <= '0;
          end else begin
            hdr_cnt <= hdr_cnt + 1'b1;
          end
        end else begin
          cap <= cap_next;
          if (slot == SLOT_LAST) begin
            frame_bits <= cap_next;
            frame_done <= 1'b1;
            hdr        <= 1'b1;
            slot       <= '0;
          end else begin
            slot <= slot + 1'b1;
          end
        end
      end
    end
  end

  assign bus_pull = hdr ? (hdr_cnt < SYNC_N)
                        : ((sub < SHORT_END) || (stretch && (sub < LONG_END)));
  assign in_sync  = hdr;
  assign slot_idx = slot;
endmodule

module oc_frame_master_chk #(
  parameter int NBITS = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick,
  input logic                     bus_pull,
  input logic                     in_sync,
  input logic [$clog2(NBITS)-1:0] slot_idx,
  input logic                     frame_done
);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_done_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(tick));
  assert_done_enters_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> in_sync);
  assert_sync_slot_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |-> slot_idx == '0);
  assert_bus_only_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(bus_pull) && $stable(in_sync) && $stable(slot_idx));
endmodule

bind oc_frame_master oc_frame_master_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_pull(bus_pull),
  .in_sync(in_sync), .slot_idx(slot_idx), .frame_done(frame_done)
);

// File: tb/oc_frame_master_tb.sv
`timescale 1ns/1ps
module oc_frame_master_tb;
  localparam int N   = 8;
  localparam int ST  = 20;
  localparam int HDR = 3 * ST;
  localparam int F   = HDR + N * ST;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, req_seen = 1'b0;
  logic bus_pull, in_sync, frame_done;
  logic [2:0] slot_idx;
  logic [N-1:0] frame_bits;

  int checks = 0, errors = 0;
  int req_at[N];
  bit req_all;

  always #2.5 clk = ~clk;

  oc_frame_master u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_seen(req_seen),
    .bus_pull(bus_pull), .in_sync(in_sync), .slot_idx(slot_idx),
    .frame_bits(frame_bits), .frame_done(frame_done)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic bit accepted(int d);
    return req_all || (req_at[d] >= 1 && req_at[d] <= 4);
  endfunction

  task automatic run_frame();
    logic [N-1:0] exp_bits;
    for (int i = 0; i < N; i++) exp_bits[i] = accepted(i);
    for (int k = 0; k < F; k++) begin
      int p, d, s;
      bit eb;
      @(negedge clk); tick = 1'b1; req_seen = req_all;
      @(negedge clk); tick = 1'b0;
      p = (k + 1) % F;
      d = (p - HDR) / ST;
      s = (p - HDR) % ST;
      if (p >= HDR && req_at[d] == s) req_seen = 1'b1;
      if (k == F - 1) begin
        check(frame_done == 1'b1, "R6 done", frame_done, 1);
        check(frame_bits == exp_bits, "R6 bits", frame_bits, exp_bits);
      end else begin
        check(frame_done == 1'b0, "R6 idle", frame_done, 0);
      end
      repeat (3) @(negedge clk);
      if (p < HDR) begin
        eb = (p < 2 * ST);
        check(bus_pull == eb, "R2 R5 header line", bus_pull, eb);
        check(in_sync == 1'b1 && slot_idx == 0, "R1 header", {in_sync, slot_idx}, 8);
      end else begin
        eb = (s < 5) || (accepted(d) && s < 15);
        check(bus_pull == eb, accepted(d) ? "R4 long" : "R3 R5 short", bus_pull, eb);
        check(in_sync == 1'b0 && slot_idx == d[2:0], "R1 slot", {in_sync, slot_idx}, d);
      end
      req_seen = req_all;
    end
  endtask

  task automatic frame_zeros();
    for (int i = 0; i < N; i++) req_at[i] = -1;
    req_all = 0; run_frame();
  endtask

  task automatic frame_ones();
    for (int i = 0; i < N; i++) req_at[i] = 1 + i % 4;
    req_all = 0; run_frame();
  endtask

  task automatic frame_mixed();
    req_at = '{0, 5, 2, 19, 4, 10, -1, 1};
    req_all = 0; run_frame();
  endtask

  task automatic frame_held();
    for (int i = 0; i < N; i++) req_at[i] = -1;
    req_all = 1; run_frame();
    req_all = 0; req_seen = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bus_pull == 1'b1 && in_sync == 1'b1, "R8 line", {bus_pull, in_sync}, 3);
    check(slot_idx == 0 && frame_bits == 0 && frame_done == 0, "R8 regs", frame_bits, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(bus_pull == 1'b1 && in_sync == 1'b1 && slot_idx == 0, "R8 after release", bus_pull, 1);
    frame_zeros();
    frame_ones();
    frame_mixed();
    frame_held();
    frame_zeros();
    finish_run();
  end
endmodule